// File: doc/BRIEF.md
# PHY Interrupt and Sticky Status Unit

This unit sits beside a 10/100 Ethernet PHY core and turns its event indications into software-visible status. Live link, speed and duplex levels are watched for changes. Next-page, false-carrier and bad end-of-stream-delimiter strobes are caught as single-cycle pulses. Each event is latched into a flag that holds until software reads the register containing it. The descrambler lock state is passed through as a live bit.

Two registers are exposed to a management-interface front end through a simple read/write strobe port. The error register holds the two error flags and the live lock bit. The interrupt register holds the global enable, the per-source masks, the master mask and the four latched interrupt events. An active-low interrupt line is driven from the latched events after masking.

Top module: `phy_irq_status`

## Requirements
- R1: A `false_carrier_i` pulse sets bit 1 of the error register (address 0). The bit stays set until that register is read.
- R2: A `bad_esd_i` pulse sets bit 2 of the error register. The bit stays set until that register is read.
- R3: Bit 0 of the error register follows `scr_lock_i` live and is never latched.
- R4: Any change of `link_up_i`, `speed_hi_i` or `full_dup_i` latches event bit 1, 2 or 3 respectively of the interrupt register (address 1). A `np_rcvd_i` pulse latches event bit 4.
- R5: A read strobe clears the latched flags of the register being read. An event arriving in the same cycle as that read leaves its flag set afterwards.
- R6: Writes to address 1 load the global enable (bit 14), the masks for next-page (12), duplex (11), speed (10) and link (9), and the master mask (8). Written event bits are ignored, and writes to address 0 change nothing. Unused bits read 0.
- R7: `irq_no` is low exactly when the global enable is 1, the master mask is 0, and at least one latched event whose mask bit is 0 is pending.
- R8: After reset all flags are 0, the interrupt register reads 0x1F00 (disabled, everything masked), and no change event is latched in the first cycle after reset, whatever the input levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_up_i | input | 1 | Live link status level |
| speed_hi_i | input | 1 | Live speed level (1 = 100 Mb/s) |
| full_dup_i | input | 1 | Live duplex level (1 = full) |
| np_rcvd_i | input | 1 | Pulse: link-partner next page received |
| false_carrier_i | input | 1 | Pulse: false carrier seen |
| bad_esd_i | input | 1 | Pulse: bad end-of-stream delimiter seen |
| scr_lock_i | input | 1 | Live descrambler lock state |
| reg_addr_i | input | 2 | Register address (0 error, 1 interrupt) |
| reg_rd_i | input | 1 | Read strobe; clears the addressed flags |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the addressed register (combinational) |
| irq_no | output | 1 | Interrupt, active low |

## Verification
Stimulus moves each live level on its own, then raises several events together, so that bits 1 to 3 show which input caused each flag. Mask patterns are stepped from all-clear to per-source, then master-masked, then globally disabled. This separates a pending event that correctly raises the line from one that is masked or gated off. Reads are issued both on quiet cycles and together with a fresh event, which tells a proper clear-on-read from one that loses the coincident event. A reset taken with the levels held high shows that no spurious change is latched.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 16;
  localparam int N_SRC  = 4;            // np, fdx, spd, lnk
  localparam int N_LVL  = 3;            // fdx, spd, lnk

  localparam logic [REG_AW-1:0] ADDR_ERR = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_INT = 2'd1;

  localparam int BIT_GEN   = 14;
  localparam int BIT_MASK0 = 9;         // masks occupy 12:9
  localparam int BIT_MSTR  = 8;
  localparam int BIT_EV0   = 1;         // events occupy 4:1

  localparam int BIT_LOCK  = 0;
  localparam int BIT_FC    = 1;
  localparam int BIT_ESD   = 2;

  typedef struct packed {
    logic             gen_en;
    logic [N_SRC-1:0] src_mask;         // {np, fdx, spd, lnk}
    logic             mstr_mask;
  } irq_ctrl_t;

  localparam irq_ctrl_t CTRL_RST = '{gen_en: 1'b0, src_mask: '1, mstr_mask: 1'b1};
endpackage

// File: rtl/phy_irq_chg.sv
module phy_irq_chg #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] chg_o
);
  logic primed_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= lvl_i[i];
    end
    assign chg_o[i] = primed_q & (lvl_i[i] ^ prev_q[i]);
  end

  // R4: once primed, every toggle since the last edge is flagged
  assert_toggle_flagged_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_q && (lvl_i != $past(lvl_i)) |-> chg_o == (lvl_i ^ $past(lvl_i)));
endmodule

// File: rtl/phy_irq_sticky.sv
module phy_irq_sticky #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  // set wins over clear so a coincident event survives the read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & {W{~clr_i}}) | set_i;
  end

  assign flag_o = flag_q;

  assert_set_survives_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i != '0 |=> (flag_o & $past(set_i)) == $past(set_i));

  assert_hold_until_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (flag_o & $past(flag_o)) == $past(flag_o));
endmodule

// File: rtl/phy_irq_status.sv
module phy_irq_status
  import phy_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              link_up_i,
  input  logic              speed_hi_i,
  input  logic              full_dup_i,
  input  logic              np_rcvd_i,
  input  logic              false_carrier_i,
  input  logic              bad_esd_i,
  input  logic              scr_lock_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              irq_no
);
  irq_ctrl_t        ctrl_q;
  logic [N_LVL-1:0] lvl_chg;
  logic [N_SRC-1:0] ev_set, ev_q;
  logic [1:0]       err_set, err_q;
  logic             rd_int, rd_err, wr_int, pend;
  logic [REG_DW-1:0] wdata_unused;

  assign rd_int = reg_rd_i && (reg_addr_i == ADDR_INT);
  assign rd_err = reg_rd_i && (reg_addr_i == ADDR_ERR);
  assign wr_int = reg_wr_i && (reg_addr_i == ADDR_INT);
  assign wdata_unused = reg_wdata_i;

  phy_irq_chg #(.W(N_LVL)) i_chg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  ({full_dup_i, speed_hi_i, link_up_i}),
    .chg_o  (lvl_chg)
  );

  assign ev_set = {np_rcvd_i, lvl_chg};

  phy_irq_sticky #(.W(N_SRC)) i_ev (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ev_set),
    .clr_i  (rd_int),
    .flag_o (ev_q)
  );

  assign err_set = {bad_esd_i, false_carrier_i};

  phy_irq_sticky #(.W(2)) i_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err_set),
    .clr_i  (rd_err),
    .flag_o (err_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else if (wr_int) begin
      ctrl_q.gen_en    <= reg_wdata_i[BIT_GEN];
      ctrl_q.src_mask  <= reg_wdata_i[BIT_MASK0 +: N_SRC];
      ctrl_q.mstr_mask <= reg_wdata_i[BIT_MSTR];
    end
  end

  assign pend   = |(ev_q & ~ctrl_q.src_mask);
  assign irq_no = ~(ctrl_q.gen_en & ~ctrl_q.mstr_mask & pend);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_ERR: begin
        reg_rdata_o[BIT_LOCK] = scr_lock_i;
        reg_rdata_o[BIT_FC]   = err_q[0];
        reg_rdata_o[BIT_ESD]  = err_q[1];
      end
      ADDR_INT: begin
        reg_rdata_o[BIT_GEN]               = ctrl_q.gen_en;
        reg_rdata_o[BIT_MASK0 +: N_SRC]    = ctrl_q.src_mask;
        reg_rdata_o[BIT_MSTR]              = ctrl_q.mstr_mask;
        reg_rdata_o[BIT_EV0 +: N_SRC]      = ev_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assert_ctrl_only_via_int_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_int |=> $stable(ctrl_q));

  assert_irq_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> ctrl_q.gen_en && !ctrl_q.mstr_mask && ev_q != '0);
endmodule

// File: tb/test_phy_irq_status.sv
module test_phy_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 22;

  typedef struct packed {
    logic [2:0]  lvl;      // {fdx, spd, lnk}
    logic        np;
    logic        fc;
    logic        esd;
    logic        lock;
    logic        rd;
    logic        wr;
    logic [1:0]  addr;
    logic [15:0] wdata;
    logic [15:0] exp_rd;
    logic        exp_irqn;
  } vec_t;

  // rows checked before the edge that applies them
  localparam vec_t VECS [N_VEC] = '{
    '{3'b000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,16'h0000,16'h1F00,1'b1}, // R8
    '{3'b000,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,16'h4000,16'h1F00,1'b1}, // R6
    '{3'b001,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,16'h0000,16'h4000,1'b1}, // R6
    '{3'b001,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,16'h0000,16'h4002,1'b0}, // R4 R7
    '{3'b001,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,16'h0000,16'h4000,1'b1}, // R5
    '{3'b011,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,16'h4200,16'h4000,1'b1}, // R6
    '{3'b011,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,16'h0000,16'h4204,1'b0}, // R4 R7
    '{3'b011,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,16'h4500,16'h4204,1'b0}, // R7
    '{3'b011,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,16'h0000,16'h4504,1'b1}, // R7 master
    '{3'b111,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,16'h4000,16'h4504,1'b1}, // R7
    '{3'b111,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,16'h0000,16'h400C,1'b0}, // R4 R5
    '{3'b111,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,16'h0000,16'h4010,1'b0}, // R5 np kept
    '{3'b111,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd1,16'h0000,16'h4010,1'b0}, // R4
    '{3'b111,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,16'h0000,16'h0001,1'b1}, // R3
    '{3'b111,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,2'd0,16'h0000,16'h0003,1'b1}, // R1 R5
    '{3'b111,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,16'h0000,16'h0006,1'b1}, // R1 R2 R3
    '{3'b111,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,16'h0000,16'h0006,1'b1}, // R2
    '{3'b111,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,16'h0000,16'h0001,1'b1}, // R1 R2 cleared
    '{3'b111,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,2'd0,16'hFFFF,16'h0001,1'b1}, // R6
    '{3'b111,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd1,16'h001E,16'h4000,1'b1}, // R6
    '{3'b110,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,16'h0000,16'h0000,1'b1}, // R6 ev bits unwritable
    '{3'b110,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,16'h0000,16'h0002,1'b1}  // R4 R7 disabled
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lnk = 0, spd = 0, fdx = 0, np = 0, fc = 0, esd = 0, lock = 0;
  logic [1:0]  addr = '0;
  logic rd = 0, wr = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq_n;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_irq_status i_phy_irq_status (
    .clk_i(clk), .rst_ni(rst_n),
    .link_up_i(lnk), .speed_hi_i(spd), .full_dup_i(fdx),
    .np_rcvd_i(np), .false_carrier_i(fc), .bad_esd_i(esd), .scr_lock_i(lock),
    .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_no(irq_n)
  );

  task automatic check(input string req, input logic [15:0] exp_rd, input logic exp_irqn);
    n_chk++;
    if (rdata !== exp_rd || irq_n !== exp_irqn) begin
      n_bad++;
      $display("FAIL %s: rdata=%h irq_n=%b expected rdata=%h irq_n=%b",
               req, rdata, irq_n, exp_rd, exp_irqn);
    end
  endtask

  task automatic idle();
    {np, fc, esd, rd, wr} = '0;
    wdata = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    addr = 2'd1;
    #1 check("R8 reset int reg", 16'h1F00, 1'b1);
    addr = 2'd0;
    #1 check("R8 reset err reg", 16'h0000, 1'b1);
    rst_n = 1'b1;
    step();
    step();

    for (int v = 0; v < N_VEC; v++) begin
      {fdx, spd, lnk} = VECS[v].lvl;
      np = VECS[v].np; fc = VECS[v].fc; esd = VECS[v].esd; lock = VECS[v].lock;
      rd = VECS[v].rd; wr = VECS[v].wr; addr = VECS[v].addr; wdata = VECS[v].wdata;
      #1 check($sformatf("vector %0d", v), VECS[v].exp_rd, VECS[v].exp_irqn);
      step();
    end
    idle();

    // R8: reset taken with levels high latches no change event
    {fdx, spd, lnk} = 3'b111;
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step(); step(); step();
    addr = 2'd1; lock = 1'b0;
    #1 check("R8 no event after reset", 16'h1F00, 1'b1);
    addr = 2'd0;
    #1 check("R8 err flags clear", 16'h0000, 1'b1);

    // R7: enabled and unmasked but nothing pending
    addr = 2'd1; wr = 1'b1; wdata = 16'h4000;
    step(); idle();
    #1 check("R7 no pending", 16'h4000, 1'b1);
    np = 1'b1;
    step(); idle();
    #1 check("R7 np pending", 16'h4010, 1'b0);
    wr = 1'b1; wdata = 16'h5000;     // mask np only
    step(); idle();
    #1 check("R7 np masked", 16'h5010, 1'b1);
    wr = 1'b1; wdata = 16'h4100;     // unmask np, set master
    step(); idle();
    #1 check("R7 master masked", 16'h4110, 1'b1);
    addr = 2'd2;
    #1 check("R6 unused address reads 0", 16'h0000, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule